// File: doc/BRIEF.md
# Synchronous PWM Update Controller

This block runs a small group of PWM channels. Each channel has a period, a duty-cycle value and a dead-time count. Each of these values is held twice: in an update register that software writes, and in an active register that drives the counter and the comparator. Channel 0 is the reference channel. Every channel whose sync bit is set joins channel 0 in a synchronous group. Members of the group count on channel 0's counter and start and stop with it.

For the group, new values move from the update registers to the active registers only when two conditions hold. Software must have armed a self-clearing unlock bit, and channel 0's counter must be wrapping to zero. All members then take their new values on the same clock edge, so one period never mixes old and new settings. Channels outside the group run their own counters. They take their update values at the end of each of their own periods, with no lock.

Each channel has a normal output and a complementary output. The rising edge of either output is held back by the channel's dead-time count.

Top module: `pwm_sync_upd`

## Requirements
- R1: After reset, all update and active registers, all counters and the unlock bit read 0, all channels are disabled, and every output is low.
- R2: The register address is {bank, channel, field}. Bank 0 fields 0, 1 and 2 are the writable update registers for period, duty and dead time. Bank 0 field 3 is the control word, with the unlock bit at bit 0. Bank 1 is read-only: fields 0 to 2 return the active period, duty and dead time, and field 3 returns the counter the channel uses. Writes to bank 1 change nothing.
- R3: A pulse on `en_set[0]` enables channel 0 and every channel whose sync bit is set. A pulse on `en_clr[0]` disables them all. Enable and disable pulses on any other group member are ignored. Channel 0 is always a member. If set and clear arrive together, clear wins.
- R4: Writing 1 to the unlock bit arms it, and it then reads 1 until the group transfer takes place. Writing 0 to it does nothing.
- R5: While the unlock bit is 0, the active registers of group members never change, however often the update registers are rewritten.
- R6: The group transfer fires on the edge that ends the cycle in which channel 0 is enabled and its counter equals its active period, provided the unlock bit is 1 and the mode is 0. On that edge, every member copies all three update registers into its active registers and the unlock bit clears. The value copied is the last one written before that edge.
- R7: While the mode field is not 0, no group transfer takes place and an armed unlock bit stays armed.
- R8: An enabled counter steps from 0 up to its active period and then returns to 0, so one period lasts period+1 cycles. A disabled counter holds 0. Group members use channel 0's counter.
- R9: A channel outside the group counts on its own. It copies its update registers into its active registers at the end of each of its own periods, whatever the unlock bit holds.
- R10: The raw level of a channel is (counter < duty). The outputs follow the raw level one cycle later. After each change of the raw level, both outputs stay low for as many cycles as the dead-time count. After that, the normal output equals the raw level and the complementary output equals its inverse. Both outputs are low while the channel is disabled, and they are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write address {bank, channel, field} |
| wr_data | input | CW | Write data |
| rd_addr | input | AW | Read address, combinational read |
| rd_data | output | CW | Read data |
| sync_mask | input | NCH | Group membership, one bit per channel |
| mode | input | 2 | Update mode; 0 selects manual write with manual trigger |
| en_set | input | NCH | Enable pulses, one per channel |
| en_clr | input | NCH | Disable pulses, one per channel |
| pwm_h | output | NCH | Normal PWM outputs |
| pwm_l | output | NCH | Complementary PWM outputs |

## Verification
The update path is tried in four ways, each of which separates a different kind of fault:
- Arming when channel 0 has a one-cycle period shows whether the transfer waits for the wrap and clears the bit on it.
- Arming early in a ten-cycle period and then rewriting a duty value shows whether the latest write wins and whether the bit stays set until the boundary.
- Rewriting values with the bit unarmed, or armed in a nonzero mode, over several periods shows whether anything leaks past the lock.
- Free-running channels outside the group show whether they keep loading on their own with no unlock.

A behavioural reference model, compared with the outputs and the read port on every clock, catches dead-time and counter-wrap errors.

// File: rtl/pwm_sync_pkg.sv
package pwm_sync_pkg;
  typedef enum logic [1:0] {
    FLD_PRD  = 2'd0,
    FLD_DUTY = 2'd1,
    FLD_DT   = 2'd2,
    FLD_CTL  = 2'd3
  } field_e;

  localparam logic [1:0] MODE_MANUAL = 2'd0;
endpackage

// File: rtl/pwm_sync_cnt.sv
module pwm_sync_cnt #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [CW-1:0] prd,
  output logic [CW-1:0] cnt,
  output logic          wrap
);
  function automatic logic [CW-1:0] step_count(input logic [CW-1:0] c, input logic [CW-1:0] p);
    return (c == p) ? '0 : c + CW'(1);
  endfunction

  assign wrap = run && (cnt == prd);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else             cnt <= step_count(cnt, prd);
  end
endmodule

// File: rtl/pwm_sync_dt.sv
module pwm_sync_dt #(
  parameter int CW  = 8,
  parameter int DTW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic [CW-1:0]  cnt,
  input  logic [CW-1:0]  duty,
  input  logic [DTW-1:0] dt,
  output logic           out_h,
  output logic           out_l
);
  logic           raw;
  logic           raw_q;
  logic [DTW-1:0] hold_q;

  function automatic logic level_of(input logic [CW-1:0] c, input logic [CW-1:0] d);
    return c < d;
  endfunction

  assign raw = en && level_of(cnt, duty);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      raw_q  <= 1'b0;
      hold_q <= '0;
    end else begin
      raw_q <= raw;
      if (raw != raw_q)     hold_q <= dt;
      else if (hold_q != 0) hold_q <= hold_q - DTW'(1);
    end
  end

  assign out_h = en && raw_q  && (hold_q == 0);
  assign out_l = en && !raw_q && (hold_q == 0);
endmodule

// File: rtl/pwm_sync_bank.sv
module pwm_sync_bank import pwm_sync_pkg::*; #(
  parameter int NCH = 4,
  parameter int CW  = 8,
  parameter int DTW = 4,
  parameter int CHW = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           upd_we,
  input  logic [CHW-1:0] upd_ch,
  input  field_e         upd_fld,
  input  logic [CW-1:0]  wdata,
  input  logic           arm_wr,
  input  logic           grp_xfer,
  input  logic [NCH-1:0] ld,
  output logic [CW-1:0]  upd_prd  [NCH],
  output logic [CW-1:0]  upd_duty [NCH],
  output logic [DTW-1:0] upd_dt   [NCH],
  output logic [CW-1:0]  act_prd  [NCH],
  output logic [CW-1:0]  act_duty [NCH],
  output logic [DTW-1:0] act_dt   [NCH],
  output logic           unlock_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCH; i++) begin
        upd_prd[i]  <= '0;
        upd_duty[i] <= '0;
        upd_dt[i]   <= '0;
        act_prd[i]  <= '0;
        act_duty[i] <= '0;
        act_dt[i]   <= '0;
      end
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (ld[i]) begin
          act_prd[i]  <= upd_prd[i];
          act_duty[i] <= upd_duty[i];
          act_dt[i]   <= upd_dt[i];
        end
        if (upd_we && (int'(upd_ch) == i)) begin
          unique case (upd_fld)
            FLD_PRD:  upd_prd[i]  <= wdata;
            FLD_DUTY: upd_duty[i] <= wdata;
            FLD_DT:   upd_dt[i]   <= wdata[DTW-1:0];
            default:  ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           unlock_q <= 1'b0;
    else if (arm_wr)   unlock_q <= 1'b1;
    else if (grp_xfer) unlock_q <= 1'b0;
  end
endmodule

// File: rtl/pwm_sync_upd.sv
module pwm_sync_upd import pwm_sync_pkg::*; #(
  parameter  int NCH = 4,
  parameter  int CW  = 8,
  parameter  int DTW = 4,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int AW  = CHW + 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [CW-1:0]  wr_data,
  input  logic [AW-1:0]  rd_addr,
  output logic [CW-1:0]  rd_data,
  input  logic [NCH-1:0] sync_mask,
  input  logic [1:0]     mode,
  input  logic [NCH-1:0] en_set,
  input  logic [NCH-1:0] en_clr,
  output logic [NCH-1:0] pwm_h,
  output logic [NCH-1:0] pwm_l
);
  logic [NCH-1:0] en_q, sync_eff, run, en_eff, wrap, ld;
  logic [CW-1:0]  cnt     [NCH];
  logic [CW-1:0]  cnt_eff [NCH];
  logic [CW-1:0]  upd_prd  [NCH];
  logic [CW-1:0]  upd_duty [NCH];
  logic [DTW-1:0] upd_dt   [NCH];
  logic [CW-1:0]  act_prd  [NCH];
  logic [CW-1:0]  act_duty [NCH];
  logic [DTW-1:0] act_dt   [NCH];
  logic           unlock_q, grp_wrap, grp_xfer;
  logic [CW-1:0]  cnt0;

  field_e         wr_fld, rd_fld;
  logic [CHW-1:0] wr_ch, rd_ch;
  logic           wr_bank, rd_bank, wr_ch_ok, rd_ch_ok;
  logic           upd_we, arm_wr;

  assign wr_fld   = field_e'(wr_addr[1:0]);
  assign wr_ch    = wr_addr[CHW+1:2];
  assign wr_bank  = wr_addr[AW-1];
  assign wr_ch_ok = int'(wr_ch) < NCH;
  assign rd_fld   = field_e'(rd_addr[1:0]);
  assign rd_ch    = rd_addr[CHW+1:2];
  assign rd_bank  = rd_addr[AW-1];
  assign rd_ch_ok = int'(rd_ch) < NCH;

  assign upd_we = wr_en && !wr_bank && wr_ch_ok && (wr_fld != FLD_CTL);
  assign arm_wr = wr_en && !wr_bank && (wr_fld == FLD_CTL) && wr_data[0];

  assign grp_wrap = wrap[0];
  assign grp_xfer = grp_wrap && unlock_q && (mode == MODE_MANUAL);
  assign cnt0     = cnt[0];

  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else begin
      for (int i = 0; i < NCH; i++) begin
        if ((i == 0) || !sync_eff[i]) begin
          if (en_clr[i])      en_q[i] <= 1'b0;
          else if (en_set[i]) en_q[i] <= 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign sync_eff[g] = (g == 0) || sync_mask[g];
    assign run[g]      = (g == 0) ? en_q[0] : (!sync_eff[g] && en_q[g]);
    assign en_eff[g]   = sync_eff[g] ? en_q[0] : en_q[g];
    assign cnt_eff[g]  = sync_eff[g] ? cnt[0] : cnt[g];
    assign ld[g]       = sync_eff[g] ? grp_xfer : wrap[g];

    pwm_sync_cnt #(.CW(CW)) u_cnt (
      .clk  (clk),
      .rst  (rst),
      .run  (run[g]),
      .prd  (act_prd[g]),
      .cnt  (cnt[g]),
      .wrap (wrap[g])
    );

    pwm_sync_dt #(.CW(CW), .DTW(DTW)) u_dt (
      .clk   (clk),
      .rst   (rst),
      .en    (en_eff[g]),
      .cnt   (cnt_eff[g]),
      .duty  (act_duty[g]),
      .dt    (act_dt[g]),
      .out_h (pwm_h[g]),
      .out_l (pwm_l[g])
    );
  end

  pwm_sync_bank #(.NCH(NCH), .CW(CW), .DTW(DTW), .CHW(CHW)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .upd_we   (upd_we),
    .upd_ch   (wr_ch),
    .upd_fld  (wr_fld),
    .wdata    (wr_data),
    .arm_wr   (arm_wr),
    .grp_xfer (grp_xfer),
    .ld       (ld),
    .upd_prd  (upd_prd),
    .upd_duty (upd_duty),
    .upd_dt   (upd_dt),
    .act_prd  (act_prd),
    .act_duty (act_duty),
    .act_dt   (act_dt),
    .unlock_q (unlock_q)
  );

  always_comb begin
    rd_data = '0;
    if (rd_ch_ok) begin
      unique case (rd_fld)
        FLD_PRD:  rd_data = rd_bank ? act_prd[rd_ch]  : upd_prd[rd_ch];
        FLD_DUTY: rd_data = rd_bank ? act_duty[rd_ch] : upd_duty[rd_ch];
        FLD_DT:   rd_data = rd_bank ? CW'(act_dt[rd_ch]) : CW'(upd_dt[rd_ch]);
        FLD_CTL:  rd_data = rd_bank ? cnt_eff[rd_ch] : CW'(unlock_q);
        default:  rd_data = '0;
      endcase
    end
  end
endmodule

// File: rtl/pwm_sync_chk.sv
module pwm_sync_chk #(
  parameter int NCH = 4,
  parameter int CW  = 8,
  parameter int AW  = 5
) (
  input logic           clk,
  input logic           rst,
  input logic           wr_en,
  input logic [AW-1:0]  wr_addr,
  input logic [CW-1:0]  wr_data,
  input logic [1:0]     mode,
  input logic [NCH-1:0] pwm_h,
  input logic [NCH-1:0] pwm_l,
  input logic           unlock_q,
  input logic           grp_wrap,
  input logic           grp_xfer,
  input logic [CW-1:0]  cnt0
);
  logic arm_req;
  assign arm_req = wr_en && !wr_addr[AW-1] && (wr_addr[1:0] == 2'd3) && wr_data[0];

  // R4
  arm_hold_chk: assert property (@(posedge clk) disable iff (rst)
    unlock_q && !grp_xfer |=> unlock_q);

  // R4
  no_self_arm_chk: assert property (@(posedge clk) disable iff (rst)
    !unlock_q && !arm_req |=> !unlock_q);

  // R6
  xfer_clear_chk: assert property (@(posedge clk) disable iff (rst)
    grp_xfer && !arm_req |=> !unlock_q);

  // R7
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mode != 2'd0) && unlock_q |=> unlock_q);

  // R8
  wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
    grp_wrap |=> (cnt0 == '0));

  for (genvar g = 0; g < NCH; g++) begin : g_out
    // R10
    excl_out_chk: assert property (@(posedge clk) disable iff (rst)
      !(pwm_h[g] && pwm_l[g]));
  end
endmodule

bind pwm_sync_upd pwm_sync_chk #(.NCH(NCH), .CW(CW), .AW(AW)) u_chk (.*);

// File: tb/pwm_sync_upd_test.sv
module pwm_sync_upd_test;
  localparam int NCH = 4;
  localparam int CW  = 8;
  localparam int DTW = 4;
  localparam int AW  = 5;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           wr_en = 1'b0;
  logic [AW-1:0]  wr_addr = '0;
  logic [CW-1:0]  wr_data = '0;
  logic [AW-1:0]  rd_addr = '0;
  logic [CW-1:0]  rd_data;
  logic [NCH-1:0] sync_mask = 4'b0011;
  logic [1:0]     mode = 2'd0;
  logic [NCH-1:0] en_set = '0;
  logic [NCH-1:0] en_clr = '0;
  logic [NCH-1:0] pwm_h, pwm_l;

  int checks = 0;
  int errors = 0;

  pwm_sync_upd #(.NCH(NCH), .CW(CW), .DTW(DTW)) uut (.*);

  always #5 clk = ~clk;

  // reference model state
  int u_prd[NCH], u_duty[NCH], u_dt[NCH];
  int a_prd[NCH], a_duty[NCH], a_dt[NCH];
  int cnt[NCH], rawq[NCH], dtc[NCH];
  bit en[NCH];
  bit unl;

  function automatic bit member(int i);
    return (i == 0) || sync_mask[i];
  endfunction
  function automatic bit ee(int i);
    return member(i) ? en[0] : en[i];
  endfunction
  function automatic int ce(int i);
    return member(i) ? cnt[0] : cnt[i];
  endfunction

  function automatic int model_read(logic [AW-1:0] a);
    int ch = int'(a[3:2]);
    int f  = int'(a[1:0]);
    if (!a[4]) begin
      case (f)
        0: return u_prd[ch];
        1: return u_duty[ch];
        2: return u_dt[ch];
        default: return int'(unl);
      endcase
    end
    case (f)
      0: return a_prd[ch];
      1: return a_duty[ch];
      2: return a_dt[ch];
      default: return ce(ch);
    endcase
  endfunction

  task automatic model_step();
    bit gw, xf;
    bit ld[NCH];
    gw = en[0] && (cnt[0] == a_prd[0]);
    xf = gw && unl && (mode == 2'd0);
    for (int i = 0; i < NCH; i++) begin
      bit raw;
      raw = ee(i) && (ce(i) < a_duty[i]);
      if (!ee(i)) begin rawq[i] = 0; dtc[i] = 0; end
      else begin
        if (raw != rawq[i][0]) dtc[i] = a_dt[i];
        else if (dtc[i] > 0) dtc[i]--;
        rawq[i] = int'(raw);
      end
      ld[i] = member(i) ? xf : (en[i] && (cnt[i] == a_prd[i]));
    end
    for (int i = 0; i < NCH; i++) begin
      bit r;
      r = (i == 0) ? en[0] : (!member(i) && en[i]);
      if (!r) cnt[i] = 0;
      else cnt[i] = (cnt[i] == a_prd[i]) ? 0 : cnt[i] + 1;
      if (ld[i]) begin a_prd[i] = u_prd[i]; a_duty[i] = u_duty[i]; a_dt[i] = u_dt[i]; end
    end
    if (wr_en && !wr_addr[4]) begin
      case (int'(wr_addr[1:0]))
        0: u_prd[wr_addr[3:2]]  = int'(wr_data);
        1: u_duty[wr_addr[3:2]] = int'(wr_data);
        2: u_dt[wr_addr[3:2]]   = int'(wr_data[DTW-1:0]);
        default: ;
      endcase
    end
    if (wr_en && !wr_addr[4] && wr_addr[1:0] == 2'd3 && wr_data[0]) unl = 1;
    else if (xf) unl = 0;
    for (int i = 0; i < NCH; i++) begin
      if (i == 0 || !member(i)) begin
        if (en_clr[i]) en[i] = 0;
        else if (en_set[i]) en[i] = 1;
      end
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NCH; i++) begin
      u_prd[i] = 0; u_duty[i] = 0; u_dt[i] = 0;
      a_prd[i] = 0; a_duty[i] = 0; a_dt[i] = 0;
      cnt[i] = 0; rawq[i] = 0; dtc[i] = 0; en[i] = 0;
    end
    unl = 0;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // model advance and per-cycle comparison
  always @(posedge clk) begin
    if (rst) model_reset();
    else model_step();
    #2;
    if (!rst) begin
      for (int i = 0; i < NCH; i++) begin
        int eh, el;
        eh = int'(ee(i) && rawq[i] == 1 && dtc[i] == 0);
        el = int'(ee(i) && rawq[i] == 0 && dtc[i] == 0);
        chk($sformatf("R10 pwm_h[%0d]", i), int'(pwm_h[i]), eh);
        chk($sformatf("R10 pwm_l[%0d]", i), int'(pwm_l[i]), el);
      end
      chk("R2 read port", int'(rd_data), model_read(rd_addr));
    end
  end

  function automatic logic [AW-1:0] ad(int bank, int ch, int f);
    return {bank[0], ch[1:0], f[1:0]};
  endfunction

  task automatic wr(int bank, int ch, int f, int v);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = ad(bank, ch, f); wr_data = v[CW-1:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rdv(int bank, int ch, int f, output int v);
    rd_addr = ad(bank, ch, f);
    #1;
    v = int'(rd_data);
    @(negedge clk);
  endtask

  task automatic rdchk(string tag, int bank, int ch, int f, int exp);
    int v;
    rdv(bank, ch, f, v);
    chk(tag, v, exp);
  endtask

  task automatic pulse(bit is_set, logic [NCH-1:0] v);
    @(negedge clk);
    if (is_set) en_set = v; else en_clr = v;
    @(negedge clk);
    en_set = '0; en_clr = '0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_xfer();
    int v = 1;
    for (int k = 0; k < 60 && v != 0; k++) rdv(0, 0, 3, v);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int v, mx;
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    for (int c = 0; c < NCH; c++)
      for (int f = 0; f < 4; f++) begin
        rdchk("R1 update bank", 0, c, f, 0);
        rdchk("R1 active bank", 1, c, f, 0);
      end
    chk("R1 outputs", int'({pwm_h, pwm_l}), 0);

    wr(0, 0, 0, 9); wr(0, 0, 1, 4); wr(0, 0, 2, 2);
    wr(0, 1, 0, 5); wr(0, 1, 1, 7); wr(0, 1, 2, 0);
    wr(0, 2, 0, 6); wr(0, 2, 1, 3); wr(0, 2, 2, 1);
    wr(0, 3, 0, 3); wr(0, 3, 1, 2); wr(0, 3, 2, 0);
    rdchk("R5 active period ch0 before unlock", 1, 0, 0, 0);
    rdchk("R2 update duty ch2", 0, 2, 1, 3);

    // R3: member enable pulse ignored while channel 0 is off
    pulse(1, 4'b0010);
    idle(3);
    chk("R3 member enable ignored", int'({pwm_h[1], pwm_l[1]}), 0);
    pulse(1, 4'b0001);
    idle(3);
    chk("R3 group enable via ch0", int'(pwm_l[1]), 1);

    idle(10);
    rdchk("R5 active duty ch1 locked", 1, 1, 1, 0);

    // R4 and R6 with a one-cycle period
    wr(0, 0, 3, 1);
    rdchk("R4 armed reads 1", 0, 0, 3, 1);
    idle(2);
    rdchk("R6 unlock cleared", 0, 0, 3, 0);
    rdchk("R6 period ch0", 1, 0, 0, 9);
    rdchk("R6 duty ch1", 1, 1, 1, 7);
    rdchk("R6 deadtime ch0", 1, 0, 2, 2);

    // R6: latest write before the boundary wins
    v = -1;
    for (int k = 0; k < 40 && v != 1; k++) rdv(1, 0, 3, v);
    wr(0, 0, 1, 6);
    wr(0, 0, 3, 1);
    wr(0, 0, 1, 8);
    rdchk("R4 stays armed mid-period", 0, 0, 3, 1);
    wait_xfer();
    rdchk("R6 latest duty ch0", 1, 0, 1, 8);

    // R4/R5: writing 0 does not arm
    wr(0, 0, 1, 1);
    wr(0, 0, 3, 0);
    idle(25);
    rdchk("R4 zero write no effect", 0, 0, 3, 0);
    rdchk("R5 duty ch0 held", 1, 0, 1, 8);

    // R7: nonzero mode blocks the transfer
    @(negedge clk); mode = 2'd1;
    wr(0, 0, 3, 1);
    idle(25);
    rdchk("R7 unlock kept", 0, 0, 3, 1);
    rdchk("R7 duty ch0 held", 1, 0, 1, 8);
    @(negedge clk); mode = 2'd0;
    wait_xfer();
    rdchk("R6 transfer after mode 0", 1, 0, 1, 1);

    // R9: free-running channels load without unlock
    pulse(1, 4'b1100);
    idle(12);
    rdchk("R9 period ch2", 1, 2, 0, 6);
    rdchk("R9 duty ch3", 1, 3, 1, 2);

    // R8: counter of ch3 stays within 0..3
    mx = 0;
    for (int k = 0; k < 20; k++) begin
      rdv(1, 3, 3, v);
      if (v > mx) mx = v;
    end
    chk("R8 counter max ch3", mx, 3);

    // R2: bank 1 is read-only
    wr(1, 0, 1, 8'h55);
    rdchk("R2 bank1 write ignored", 1, 0, 1, 1);

    // R3: member disable pulse ignored
    pulse(0, 4'b0010);
    idle(3);
    chk("R3 member disable ignored", int'(pwm_h[1] | pwm_l[1]), 1);

    // R8/R10: group disable
    pulse(0, 4'b0001);
    idle(2);
    chk("R10 group outputs low", int'({pwm_h[1:0], pwm_l[1:0]}), 0);
    rdchk("R8 counter ch0 held at 0", 1, 0, 3, 0);
    idle(5);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule